// File: doc/BRIEF.md
# DSP Upper-Half Logical Shifter with Condition Flags

This block performs the logical shift step of a 40-bit DSP datapath. The datapath word has a 32-bit body with 8 guard bits above it. The block takes only the upper 16-bit half of the body (bits 31..16) and shifts it left or right by a signed distance. Vacated bit positions fill with zeros. The lower half of the body and the guard field of the result are always zero, whatever the source held there.

The shift distance is a 7-bit two's-complement value. It comes either from bits 22..16 of a second source operand or from an immediate. A positive distance shifts left and a negative one shifts right. Distances beyond sixteen in either direction saturate at sixteen.

Together with the result, the block keeps a five-bit status set:
- a selectable condition bit,
- a negative bit,
- a zero bit,
- an overflow bit,
- a greater-than bit.

A mode code chooses what the selectable bit reports. The status set is rewritten by every unconditional shift. It is left alone by conditional ones. Results appear one clock after the operation is presented.

Top module: `dsp_lshift_flags`

## Requirements
- R1: A distance d in 1..16 gives result bits 31..16 equal to source bits 31..16 shifted left by d, zero filled from the bottom. Bits pushed above bit 31 are lost.
- R2: A distance -d, with d in 1..16, gives result bits 31..16 equal to source bits 31..16 shifted right by d, zero filled from the top.
- R3: A distance of 0 passes source bits 31..16 through unchanged. Distances above +16 act as +16. Distances below -16 act as -16.
- R4: Result bits 15..0 and 39..32 are always 0. Source bits 15..0 and 39..32 have no effect on any output.
- R5: The distance is the 7-bit two's-complement value of `imm_amt` when `use_imm` is 1. Otherwise it is `src_amt[22:16]`. The remaining bits of `src_amt` have no effect.
- R6: With `cs_sel` equal to 000, or any code 100..111, the selectable flag equals the last bit moved out of the 16-bit half. For a left shift by d this is source bit 31-d+1... that is, bit (32-d) of the source. For a right shift by d it is bit (15+d) of the source. For a distance of 0 it is 0.
- R7: With `cs_sel` 001 the selectable flag equals N. With 010 it equals Z. With 011 it is 0.
- R8: After an update, N equals result bit 31, Z is 1 exactly when the 40-bit result is zero, V is 0, and GT is 1 exactly when Z and N are both 0.
- R9: An operation with `cond_op` 1 never changes any status flag, whether or not `cond_met` is 1. An operation with `cond_op` 0 always updates all five flags.
- R10: An operation presented with `in_valid` 1 executes when `cond_op` is 0 or `cond_met` is 1. `out_valid` is then 1 in the following cycle with the new result. Otherwise `out_valid` is 0 in the following cycle and `result` holds its value.
- R11: While `rst` is 1 at a clock edge, `out_valid`, `result` and all flags become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| src_op | input | 40 | Source operand; only bits 31..16 are used |
| src_amt | input | 40 | Second source; bits 22..16 hold the distance |
| imm_amt | input | 7 | Immediate shift distance, two's complement |
| use_imm | input | 1 | 1 selects the immediate distance |
| cs_sel | input | 3 | Mode code for the selectable flag |
| cond_op | input | 1 | Operation is conditional |
| cond_met | input | 1 | Condition of a conditional operation holds |
| out_valid | output | 1 | Result register was written in the last cycle |
| result | output | 40 | Registered shift result |
| flag_dc | output | 1 | Selectable condition flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_gt | output | 1 | Greater-than flag |

## Verification
The bench builds the block with its default parameters: a 16-bit shifted half, 8 guard bits and a 7-bit distance field. With these values the distance field spans -64..+63. Every exact distance up to ±16 is reachable, and so are values far outside the legal range, which exercises the saturation on both sides. The 16-bit half width lets a full-width shift clear the half completely. It also lets the bench pick patterns whose last moved-out bit differs from its neighbours, so an off-by-one in the selectable flag is visible.

// File: rtl/dsp_lsh_pkg.sv
package dsp_lsh_pkg;

  typedef enum logic [2:0] {
    CS_CARRY = 3'b000,
    CS_NEG   = 3'b001,
    CS_ZERO  = 3'b010,
    CS_OVF   = 3'b011
  } cs_mode_e;

  typedef struct packed {
    logic dc;
    logic n;
    logic z;
    logic v;
    logic gt;
  } lsh_flags_t;

endpackage

// File: rtl/lsh_amount_dec.sv
module lsh_amount_dec #(
  parameter int AMT_W  = 7,
  parameter int HALF_W = 16,
  parameter int MAG_W  = $clog2(HALF_W + 1)
) (
  input  logic [AMT_W-1:0] raw_amt,
  output logic             dir_left,
  output logic [MAG_W-1:0] mag
);

  localparam int MAXV = HALF_W;

  int sv;

  always_comb begin
    sv       = int'($signed(raw_amt));
    dir_left = ~raw_amt[AMT_W-1];
    if (sv > MAXV) begin
      mag = MAG_W'(MAXV);
    end else if (sv >= 0) begin
      mag = MAG_W'(sv);
    end else if (sv < -MAXV) begin
      mag = MAG_W'(MAXV);
    end else begin
      mag = MAG_W'(-sv);
    end
  end

endmodule

// File: rtl/lsh_barrel.sv
module lsh_barrel #(
  parameter int HALF_W = 16,
  parameter int MAG_W  = $clog2(HALF_W + 1)
) (
  input  logic [HALF_W-1:0] half_in,
  input  logic              dir_left,
  input  logic [MAG_W-1:0]  mag,
  output logic [HALF_W-1:0] half_out,
  output logic              last_out
);

  localparam int WIDE_W = 2 * HALF_W;

  logic [WIDE_W-1:0] lw [0:MAG_W];
  logic [WIDE_W-1:0] rw [0:MAG_W];

  assign lw[0] = {{HALF_W{1'b0}}, half_in};
  assign rw[0] = {half_in, {HALF_W{1'b0}}};

  for (genvar s = 0; s < MAG_W; s++) begin : g_stage
    assign lw[s+1] = mag[s] ? (lw[s] << (1 << s)) : lw[s];
    assign rw[s+1] = mag[s] ? (rw[s] >> (1 << s)) : rw[s];
  end

  always_comb begin
    if (dir_left) begin
      half_out = lw[MAG_W][HALF_W-1:0];
      last_out = lw[MAG_W][HALF_W];
    end else begin
      half_out = rw[MAG_W][WIDE_W-1:HALF_W];
      last_out = rw[MAG_W][HALF_W-1];
    end
  end

endmodule

// File: rtl/lsh_flag_gen.sv
module lsh_flag_gen
  import dsp_lsh_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0] half_res,
  input  logic              last_out,
  input  logic [2:0]        cs_sel,
  output lsh_flags_t        flags
);

  logic is_zero;
  logic is_neg;

  assign is_zero = ~|half_res;
  assign is_neg  = half_res[HALF_W-1];

  always_comb begin
    flags.n  = is_neg;
    flags.z  = is_zero;
    flags.v  = 1'b0;
    flags.gt = ~is_zero & ~is_neg;
    unique case (cs_sel)
      CS_NEG:  flags.dc = is_neg;
      CS_ZERO: flags.dc = is_zero;
      CS_OVF:  flags.dc = 1'b0;
      default: flags.dc = last_out;
    endcase
  end

endmodule

// File: rtl/dsp_lshift_flags.sv
module dsp_lshift_flags
  import dsp_lsh_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int HALF_W  = 16,
  parameter int AMT_W   = 7,
  parameter int AMT_LSB = 16,
  localparam int DATA_W = GUARD_W + 2 * HALF_W,
  localparam int MAG_W  = $clog2(HALF_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_op,
  input  logic [DATA_W-1:0] src_amt,
  input  logic [AMT_W-1:0]  imm_amt,
  input  logic              use_imm,
  input  logic [2:0]        cs_sel,
  input  logic              cond_op,
  input  logic              cond_met,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_dc,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_gt
);

  logic [AMT_W-1:0]  raw_amt;
  logic              dir_left;
  logic [MAG_W-1:0]  mag;
  logic [HALF_W-1:0] half_res;
  logic              last_out;
  lsh_flags_t        nxt_flags;
  lsh_flags_t        flags_q;
  logic              exec;
  logic              upd_flags;

  logic unused_bits;
  assign unused_bits = ^{src_op[DATA_W-1:2*HALF_W], src_op[HALF_W-1:0],
                         src_amt[DATA_W-1:AMT_LSB+AMT_W], src_amt[AMT_LSB-1:0]};

  assign raw_amt   = use_imm ? imm_amt : src_amt[AMT_LSB+AMT_W-1:AMT_LSB];
  assign exec      = in_valid & (~cond_op | cond_met);
  assign upd_flags = in_valid & ~cond_op;

  lsh_amount_dec #(.AMT_W(AMT_W), .HALF_W(HALF_W), .MAG_W(MAG_W)) amt_i (
    .raw_amt  (raw_amt),
    .dir_left (dir_left),
    .mag      (mag)
  );

  lsh_barrel #(.HALF_W(HALF_W), .MAG_W(MAG_W)) bar_i (
    .half_in  (src_op[2*HALF_W-1:HALF_W]),
    .dir_left (dir_left),
    .mag      (mag),
    .half_out (half_res),
    .last_out (last_out)
  );

  lsh_flag_gen #(.HALF_W(HALF_W)) flg_i (
    .half_res (half_res),
    .last_out (last_out),
    .cs_sel   (cs_sel),
    .flags    (nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_q   <= '0;
    end else begin
      out_valid <= exec;
      if (exec) begin
        result <= {{GUARD_W{1'b0}}, half_res, {HALF_W{1'b0}}};
      end
      if (upd_flags) begin
        flags_q <= nxt_flags;
      end
    end
  end

  assign flag_dc = flags_q.dc;
  assign flag_n  = flags_q.n;
  assign flag_z  = flags_q.z;
  assign flag_v  = flags_q.v;
  assign flag_gt = flags_q.gt;

endmodule

// File: rtl/dsp_lsh_chk.sv
module dsp_lsh_chk #(
  parameter int DATA_W = 40,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        cs_sel,
  input logic              cond_op,
  input logic              cond_met,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              flag_dc,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_gt
);

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !flag_z && !flag_dc));

  a_r4_clear_fields: assert property (@(posedge clk) disable iff (rst)
    (result[HALF_W-1:0] == '0) && (result[DATA_W-1:2*HALF_W] == '0));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !flag_v);

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_op) |=> (flag_z == (result == '0)));

  a_r8_greater: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_op) |=> (flag_gt == (!flag_z && !flag_n)));

  a_r8_negative: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_op) |=> (flag_n == result[2*HALF_W-1]));

  a_r7_dc_neg: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_op && cs_sel == 3'b001) |=> (flag_dc == flag_n));

  a_r7_dc_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_op && cs_sel == 3'b010) |=> (flag_dc == flag_z));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || cond_op) |=> $stable({flag_dc, flag_n, flag_z, flag_v, flag_gt}));

  a_r10_exec_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!cond_op || cond_met)) |=> out_valid);

  a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || (cond_op && !cond_met)) |=> (!out_valid && $stable(result)));

endmodule

bind dsp_lshift_flags dsp_lsh_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cs_sel    (cs_sel),
  .cond_op   (cond_op),
  .cond_met  (cond_met),
  .out_valid (out_valid),
  .result    (result),
  .flag_dc   (flag_dc),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .flag_gt   (flag_gt)
);

// File: tb/dsp_lshift_flags_tb_top.sv
`timescale 1ns/1ps
module dsp_lshift_flags_tb_top;

  localparam int DATA_W = 40;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] src_op = '0;
  logic [DATA_W-1:0] src_amt = '0;
  logic [6:0]        imm_amt = '0;
  logic              use_imm = 1'b0;
  logic [2:0]        cs_sel = '0;
  logic              cond_op = 1'b0;
  logic              cond_met = 1'b0;
  logic              out_valid;
  logic [DATA_W-1:0] result;
  logic              flag_dc, flag_n, flag_z, flag_v, flag_gt;

  int n_chk = 0;
  int n_fail = 0;

  logic              e_valid = 1'b0;
  logic [DATA_W-1:0] e_res = '0;
  logic [4:0]        e_flags = '0;

  always #2.5 clk = ~clk;

  dsp_lshift_flags dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_op(src_op),
    .src_amt(src_amt), .imm_amt(imm_amt), .use_imm(use_imm),
    .cs_sel(cs_sel), .cond_op(cond_op), .cond_met(cond_met),
    .out_valid(out_valid), .result(result), .flag_dc(flag_dc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_gt(flag_gt)
  );

  task automatic chk(input string tag, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "out_valid", DATA_W'(out_valid), DATA_W'(e_valid));
    chk(tag, "result", result, e_res);
    chk(tag, "flags {dc,n,z,v,gt}",
        DATA_W'({flag_dc, flag_n, flag_z, flag_v, flag_gt}), DATA_W'(e_flags));
  endtask

  function automatic logic [DATA_W-1:0] mk_src(input logic [7:0] g,
                                               input logic [15:0] hi,
                                               input logic [15:0] lo);
    return {g, hi, lo};
  endfunction

  function automatic logic [DATA_W-1:0] mk_amt(input int a);
    logic [DATA_W-1:0] base;
    logic [6:0] a7;
    a7 = 7'(a);
    base = 40'hF7_E3FF_1234 & ~(40'h7F << 16);
    return base | (DATA_W'(a7) << 16);
  endfunction

  // Behavioural reference: applied at a negedge, predicts the next edge.
  task automatic step(input logic iv, input logic [DATA_W-1:0] s1,
                      input int amt, input logic ui, input int imm,
                      input logic [2:0] cs, input logic co, input logic cm,
                      input string tag);
    int a, h, r, lastb, k;
    logic n, z, dc;
    in_valid = iv; src_op = s1; use_imm = ui;
    src_amt  = mk_amt(amt);
    imm_amt  = 7'(imm);
    cs_sel   = cs; cond_op = co; cond_met = cm;
    a = ui ? imm : amt;
    a = int'($signed(7'(a)));
    if (a > 16) a = 16;
    if (a < -16) a = -16;
    h = int'(s1[31:16]);
    if (a > 0) begin
      r = (h << a) & 'hFFFF;
      lastb = (h >> (16 - a)) & 1;
    end else if (a < 0) begin
      k = -a;
      r = h >> k;
      lastb = (h >> (k - 1)) & 1;
    end else begin
      r = h;
      lastb = 0;
    end
    n = r[15];
    z = (r == 0);
    case (cs)
      3'b001:  dc = n;
      3'b010:  dc = z;
      3'b011:  dc = 1'b0;
      default: dc = lastb[0];
    endcase
    if (iv && (!co || cm)) begin
      e_valid = 1'b1;
      e_res   = {8'h00, 16'(r), 16'h0000};
    end else begin
      e_valid = 1'b0;
    end
    if (iv && !co) e_flags = {dc, n, z, 1'b0, (!z && !n)};
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, mk_src(8'h11, 16'hFFFF, 16'h2222), 3, 1'b0, 0, 3'b000, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R11");
    rst = 1'b0;

    // R1 left shifts
    step(1, mk_src(8'h00, 16'hA5C3, 16'h0000),  1, 0, 0, 3'b000, 0, 0, "R1");
    step(1, mk_src(8'h00, 16'hA5C3, 16'h0000),  4, 0, 0, 3'b000, 0, 0, "R1");
    step(1, mk_src(8'h00, 16'h0001, 16'h0000), 15, 0, 0, 3'b000, 0, 0, "R1");
    step(1, mk_src(8'h00, 16'h8000, 16'h0000), 16, 0, 0, 3'b000, 0, 0, "R1");
    step(1, mk_src(8'h00, 16'h7FFF, 16'h0000), 16, 0, 0, 3'b000, 0, 0, "R1");
    // R2 right shifts
    step(1, mk_src(8'h00, 16'hA5C3, 16'h0000), -1, 0, 0, 3'b000, 0, 0, "R2");
    step(1, mk_src(8'h00, 16'hC3C3, 16'h0000), -7, 0, 0, 3'b000, 0, 0, "R2");
    step(1, mk_src(8'h00, 16'h0001, 16'h0000), -16, 0, 0, 3'b000, 0, 0, "R2");
    step(1, mk_src(8'h00, 16'hFFFE, 16'h0000), -16, 0, 0, 3'b000, 0, 0, "R2");
    // R3 zero distance and saturation
    step(1, mk_src(8'h00, 16'h9ABC, 16'h0000),   0, 0, 0, 3'b000, 0, 0, "R3");
    step(1, mk_src(8'h00, 16'h8001, 16'h0000),  40, 0, 0, 3'b000, 0, 0, "R3");
    step(1, mk_src(8'h00, 16'h8001, 16'h0000),  63, 0, 0, 3'b000, 0, 0, "R3");
    step(1, mk_src(8'h00, 16'h8001, 16'h0000), -60, 0, 0, 3'b000, 0, 0, "R3");
    step(1, mk_src(8'h00, 16'h8001, 16'h0000), -64, 0, 0, 3'b000, 0, 0, "R3");
    // R4 guard and low source bits ignored
    step(1, mk_src(8'hFF, 16'h0000, 16'hFFFF),   2, 0, 0, 3'b000, 0, 0, "R4");
    step(1, mk_src(8'hA5, 16'h1234, 16'h5A5A),  -3, 0, 0, 3'b000, 0, 0, "R4");
    // R5 immediate versus register distance
    step(1, mk_src(8'h00, 16'h00F0, 16'h0000), -4, 1, 5, 3'b000, 0, 0, "R5");
    step(1, mk_src(8'h00, 16'h00F0, 16'h0000),  5, 1, -4, 3'b000, 0, 0, "R5");
    step(1, mk_src(8'h00, 16'h00F0, 16'h0000),  5, 0, -4, 3'b000, 0, 0, "R5");
    // R6 carry mode and reserved codes
    step(1, mk_src(8'h00, 16'h4000, 16'h0000),  2, 0, 0, 3'b101, 0, 0, "R6");
    step(1, mk_src(8'h00, 16'h0004, 16'h0000), -3, 0, 0, 3'b111, 0, 0, "R6");
    step(1, mk_src(8'h00, 16'h0008, 16'h0000), -3, 0, 0, 3'b100, 0, 0, "R6");
    step(1, mk_src(8'h00, 16'hFFFF, 16'h0000),  0, 0, 0, 3'b000, 0, 0, "R6");
    // R7 other modes
    step(1, mk_src(8'h00, 16'h4000, 16'h0000),  1, 0, 0, 3'b001, 0, 0, "R7");
    step(1, mk_src(8'h00, 16'h0001, 16'h0000), -1, 0, 0, 3'b010, 0, 0, "R7");
    step(1, mk_src(8'h00, 16'h8000, 16'h0000),  1, 0, 0, 3'b011, 0, 0, "R7");
    step(1, mk_src(8'h00, 16'h1234, 16'h0000),  0, 0, 0, 3'b010, 0, 0, "R7");
    // R8 flag definitions
    step(1, mk_src(8'h00, 16'h0123, 16'h0000),  1, 0, 0, 3'b000, 0, 0, "R8");
    step(1, mk_src(8'h00, 16'h0000, 16'hFFFF), -5, 0, 0, 3'b000, 0, 0, "R8");
    step(1, mk_src(8'h00, 16'h4321, 16'h0000),  1, 0, 0, 3'b000, 0, 0, "R8");
    // R9 conditional operations leave flags alone
    step(1, mk_src(8'h00, 16'h0000, 16'h0000),  0, 0, 0, 3'b010, 1, 1, "R9");
    step(1, mk_src(8'h00, 16'h8000, 16'h0000), -1, 0, 0, 3'b000, 1, 0, "R9");
    step(1, mk_src(8'h00, 16'h0001, 16'h0000), 16, 0, 0, 3'b000, 1, 1, "R9");
    step(1, mk_src(8'h00, 16'h0F00, 16'h0000),  3, 0, 0, 3'b001, 0, 0, "R9");
    // R10 idle cycles and unmet conditions hold the result
    idle("R10");
    idle("R10");
    step(1, mk_src(8'h00, 16'hBEEF, 16'h0000),  2, 0, 0, 3'b000, 1, 0, "R10");
    step(1, mk_src(8'h00, 16'hBEEF, 16'h0000),  2, 0, 0, 3'b000, 1, 1, "R10");
    idle("R10");
    // R11 reset in mid-stream
    step(1, mk_src(8'h00, 16'hFFFF, 16'h0000),  1, 0, 0, 3'b000, 0, 0, "R11");
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    e_valid = 1'b0; e_res = '0; e_flags = '0;
    compare_all("R11");
    rst = 1'b0;
    step(1, mk_src(8'h00, 16'h00FF, 16'h0000), -8, 0, 0, 3'b000, 0, 0, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule